// File: doc/BRIEF.md
# Port Command Slot Tracker

This block keeps the two per-port slot bitmaps of a serial storage host port with a parameterised number of command slots (32 by default): the command-issue bitmap, which says which slots hold a command that software has posted, and the active-tag bitmap, which says which queued (native command queuing) tags are still outstanding at the device. Software sets bits in either bitmap through write strobes; writes only ever add bits. The tracker scans the issue bitmap from slot 0 upward and offers the lowest pending slot to a single-command execution engine through a valid/ready handshake, one command at a time.

A slot whose active bit is set when it is dispatched is treated as a queued command; any other slot is non-queued. A queued slot's issue bit is dropped one cycle after the engine accepts it, if the engine then shows no error, busy or data-request status. A non-queued slot is remembered as the busy slot until the engine signals its completion, and its issue bit is dropped only if that completion is clean. Any completion with error halts dispatch; software recovers by clearing the port's run bit, which wipes both bitmaps. Queued completions mark tags finished, and finished tags leave the active bitmap when the engine posts its set-device-bits notification.

Top module: `sata_slot_tracker`

## Requirements
- R1: After reset the issue and active bitmaps read 0, `disp_valid` is 0 and `busy_slot` holds the idle marker, the value NUM_SLOTS rounded to the next power of two (32 with the default, i.e. bit 5 set).
- R2: A write on `issue_wr` or `active_wr` ORs its data into the addressed bitmap; a write never clears a bit.
- R3: When the run bit changes from 1 to 0 through `run_wr`, both bitmaps read 0 after that clock edge, even if a set write arrives in the same cycle; the halt state, busy slot and finished tags are cleared too.
- R4: `disp_valid` is 1 only while the run bit is 1 and the issue bitmap is nonzero; `disp_slot` is then the lowest-numbered set issue bit and `disp_queued` equals that slot's active bit.
- R5: While `eng_busy` or `eng_drq` is 1, `disp_valid` is 0 and the pending issue bits are kept for a later dispatch.
- R6: A queued slot accepted at edge k has its issue bit cleared at edge k+1 only if `eng_err`, `eng_busy` and `eng_drq` are all 0 in the cycle before edge k+1; otherwise the bit stays. `disp_valid` is 0 in that cycle.
- R7: A non-queued slot accepted by the engine becomes the busy slot; `disp_valid` stays 0 while a busy slot is held. A `nq_done` pulse returns `busy_slot` to the idle marker, and clears the busy slot's issue bit when all three status flags are 0.
- R8: A `nq_done` pulse with `eng_err` = 1 leaves the busy slot's issue bit set.
- R9: A `nq_done` or `q_done` pulse with `eng_err` = 1, or an error seen in the queued check cycle of R6, stops all dispatch until the run bit falls, even with issue bits pending.
- R10: A `q_done` pulse with `eng_err` = 0 marks tag `q_done_tag` finished; with `eng_err` = 1 it does not. A `sdb_post` pulse clears all finished tags from the active bitmap; unfinished tags stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_wr | input | 1 | Write strobe for the port run bit |
| run_wdata | input | 1 | New value of the run bit |
| issue_wr | input | 1 | Set strobe for the issue bitmap |
| issue_wdata | input | NUM_SLOTS | Bits to OR into the issue bitmap |
| active_wr | input | 1 | Set strobe for the active bitmap |
| active_wdata | input | NUM_SLOTS | Bits to OR into the active bitmap |
| eng_err | input | 1 | Engine status: error |
| eng_busy | input | 1 | Engine status: busy |
| eng_drq | input | 1 | Engine status: data request |
| disp_ready | input | 1 | Engine accepts the offered slot |
| nq_done | input | 1 | Non-queued command completion pulse |
| q_done | input | 1 | Queued command completion pulse |
| q_done_tag | input | $clog2(NUM_SLOTS) | Tag of the queued completion |
| sdb_post | input | 1 | Set-device-bits notification posted |
| disp_valid | output | 1 | A slot is offered to the engine |
| disp_slot | output | $clog2(NUM_SLOTS) | Offered slot number |
| disp_queued | output | 1 | Offered slot is a queued command |
| busy_slot | output | $clog2(NUM_SLOTS)+1 | Non-queued slot in flight, or idle marker |
| issue_bits | output | NUM_SLOTS | Current issue bitmap |
| active_bits | output | NUM_SLOTS | Current active bitmap |

## Verification
The bench goes after the moments when a bit must survive: an errored non-queued completion (a design that cleared it would let software lose the failed slot), an errored queued check cycle, and an errored queued tag through a set-device-bits post (a design that cleared it would report a failed tag as finished). It drives the run-bit fall together with a set write, which a design giving the write priority would leave partly filled, and holds busy and data-request while slots are pending, where a loose gate would dispatch into a busy engine. After an error it keeps issue bits pending with clean status, so a design without the halt would keep dispatching, and it checks that the busy-slot marker comes back so a stale slot cannot be cleared by a later completion.

// File: rtl/sst_pkg.sv
package sst_pkg;

   // Status flags reported by the execution engine.
   typedef struct packed {
      logic err;
      logic busy;
      logic drq;
   } eng_flags_t;

   // True when the engine shows neither error nor an unfinished transfer.
   function automatic logic flags_clean(eng_flags_t f);
      return !f.err && !f.busy && !f.drq;
   endfunction

   // True when the engine cannot take a new command.
   function automatic logic flags_blocking(eng_flags_t f);
      return f.busy || f.drq;
   endfunction

endpackage

// File: rtl/sst_first_set.sv
// Lowest-index set bit finder for the dispatch scan.
module sst_first_set #(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

   assign any = |vec;

endmodule

// File: rtl/sst_active_ctl.sv
// Active-tag bitmap with finished-tag accumulation.
module sst_active_ctl #(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wipe,
   input  logic             set_wr,
   input  logic [N-1:0]     set_data,
   input  logic             done,
   input  logic [IDX_W-1:0] done_tag,
   input  logic             done_err,
   input  logic             post,
   output logic [N-1:0]     active
);

   logic [N-1:0] finished;
   logic [N-1:0] fin_add;
   logic [N-1:0] set_mask;

   generate
      for (genvar g = 0; g < N; g++) begin : g_tag
         assign fin_add[g] = done && !done_err && (done_tag == IDX_W'(g));
      end
   endgenerate

   assign set_mask = set_wr ? set_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= '0;
         finished <= '0;
      end else if (wipe) begin
         active   <= '0;
         finished <= '0;
      end else begin
         active   <= (active | set_mask) & ~(post ? finished : '0);
         finished <= (post ? '0 : finished) | fin_add;
      end
   end

endmodule

// File: rtl/sst_dispatch_ctl.sv
// Dispatch gating, busy-slot tracking, queued check cycle and halt state.
module sst_dispatch_ctl
   import sst_pkg::*;
#(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_wr,
   input  logic             run_wdata,
   input  logic             pend_any,
   input  logic [IDX_W-1:0] pick_idx,
   input  logic             pick_queued,
   input  logic             disp_ready,
   input  eng_flags_t       flags,
   input  logic             nq_done,
   input  logic             q_done,
   output logic             disp_valid,
   output logic             run_fall,
   output logic             run_q,
   output logic             halt,
   output logic [N-1:0]     clr_vec,
   output logic [IDX_W:0]   busy_slot
);

   localparam logic [IDX_W:0] BUSY_NONE = {1'b1, {IDX_W{1'b0}}};

   logic             busy_vld;
   logic             qchk;
   logic [IDX_W-1:0] qslot;
   logic             accept;
   logic             clean;
   logic             err_seen;

   assign clean      = flags_clean(flags);
   assign busy_vld   = (busy_slot != BUSY_NONE);
   assign run_fall   = run_wr && run_q && !run_wdata;
   assign disp_valid = run_q && pend_any && !flags_blocking(flags) &&
                       !halt && !busy_vld && !qchk;
   assign accept     = disp_valid && disp_ready;
   assign err_seen   = flags.err && (nq_done || q_done || qchk);

   generate
      for (genvar g = 0; g < N; g++) begin : g_clr
         assign clr_vec[g] = clean &&
            ((qchk && (qslot == IDX_W'(g))) ||
             (nq_done && busy_vld && (busy_slot[IDX_W-1:0] == IDX_W'(g))));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         halt      <= 1'b0;
         busy_slot <= BUSY_NONE;
         qchk      <= 1'b0;
         qslot     <= '0;
      end else begin
         if (run_wr) run_q <= run_wdata;
         if (run_fall) begin
            halt      <= 1'b0;
            busy_slot <= BUSY_NONE;
            qchk      <= 1'b0;
         end else begin
            halt <= halt || err_seen;
            qchk <= accept && pick_queued;
            if (nq_done)
               busy_slot <= BUSY_NONE;
            else if (accept && !pick_queued)
               busy_slot <= {1'b0, pick_idx};
         end
         if (accept) qslot <= pick_idx;
      end
   end

endmodule

// File: rtl/sata_slot_tracker.sv
// Command slot tracker for one host port.
module sata_slot_tracker
   import sst_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   parameter int TAG_W     = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run_wr,
   input  logic                 run_wdata,
   input  logic                 issue_wr,
   input  logic [NUM_SLOTS-1:0] issue_wdata,
   input  logic                 active_wr,
   input  logic [NUM_SLOTS-1:0] active_wdata,
   input  logic                 eng_err,
   input  logic                 eng_busy,
   input  logic                 eng_drq,
   input  logic                 disp_ready,
   input  logic                 nq_done,
   input  logic                 q_done,
   input  logic [TAG_W-1:0]     q_done_tag,
   input  logic                 sdb_post,
   output logic                 disp_valid,
   output logic [TAG_W-1:0]     disp_slot,
   output logic                 disp_queued,
   output logic [TAG_W:0]       busy_slot,
   output logic [NUM_SLOTS-1:0] issue_bits,
   output logic [NUM_SLOTS-1:0] active_bits
);

   generate
      if (NUM_SLOTS < 2 || NUM_SLOTS > 64) begin : g_bad_slots
         $error("sata_slot_tracker: NUM_SLOTS must lie in 2..64");
      end
      if (TAG_W != $clog2(NUM_SLOTS)) begin : g_bad_tag
         $error("sata_slot_tracker: TAG_W must equal clog2(NUM_SLOTS)");
      end
   endgenerate

   eng_flags_t           flags;
   logic                 pend_any;
   logic                 run_fall;
   logic                 run_q;
   logic                 halt;
   logic [NUM_SLOTS-1:0] clr_vec;
   logic [NUM_SLOTS-1:0] issue_set;

   assign flags       = '{err: eng_err, busy: eng_busy, drq: eng_drq};
   assign issue_set   = issue_wr ? issue_wdata : '0;
   assign disp_queued = active_bits[disp_slot];

   sst_first_set #(.N(NUM_SLOTS), .IDX_W(TAG_W)) u_scan (
      .vec (issue_bits),
      .any (pend_any),
      .idx (disp_slot)
   );

   sst_dispatch_ctl #(.N(NUM_SLOTS), .IDX_W(TAG_W)) u_disp (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_wr      (run_wr),
      .run_wdata   (run_wdata),
      .pend_any    (pend_any),
      .pick_idx    (disp_slot),
      .pick_queued (disp_queued),
      .disp_ready  (disp_ready),
      .flags       (flags),
      .nq_done     (nq_done),
      .q_done      (q_done),
      .disp_valid  (disp_valid),
      .run_fall    (run_fall),
      .run_q       (run_q),
      .halt        (halt),
      .clr_vec     (clr_vec),
      .busy_slot   (busy_slot)
   );

   sst_active_ctl #(.N(NUM_SLOTS), .IDX_W(TAG_W)) u_act (
      .clk      (clk),
      .rst_n    (rst_n),
      .wipe     (run_fall),
      .set_wr   (active_wr),
      .set_data (active_wdata),
      .done     (q_done),
      .done_tag (q_done_tag),
      .done_err (eng_err),
      .post     (sdb_post),
      .active   (active_bits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         issue_bits <= '0;
      else if (run_fall)
         issue_bits <= '0;
      else
         issue_bits <= (issue_bits | issue_set) & ~clr_vec;
   end

endmodule

// File: rtl/sst_checker.sv
// Temporal checks for the slot tracker, attached by bind.
module sst_checker #(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_wr,
   input logic             run_wdata,
   input logic             run_q,
   input logic             halt,
   input logic             eng_err,
   input logic             eng_busy,
   input logic             eng_drq,
   input logic             nq_done,
   input logic             disp_valid,
   input logic [IDX_W-1:0] disp_slot,
   input logic [IDX_W:0]   busy_slot,
   input logic [N-1:0]     issue_bits,
   input logic [N-1:0]     active_bits
);

   localparam logic [IDX_W:0] BUSY_NONE = {1'b1, {IDX_W{1'b0}}};

   logic [N-1:0] below_mask;
   assign below_mask = (N'(1) << disp_slot) - N'(1);

   // R3: a run-bit fall wipes both bitmaps at the next edge
   p_fall_wipes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_wr && run_q && !run_wdata) |=> (issue_bits == '0 && active_bits == '0));

   // R4: the offered slot is pending and no lower slot is pending
   p_lowest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> (issue_bits[disp_slot] && ((issue_bits & below_mask) == '0) && run_q));

   // R5: nothing is offered to a busy or data-requesting engine
   p_no_offer_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy || eng_drq) |-> !disp_valid);

   // R7: a held busy slot blocks dispatch
   p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_slot != BUSY_NONE) |-> !disp_valid);

   // R7: a non-queued completion returns the busy slot to idle
   p_busy_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nq_done |=> (busy_slot == BUSY_NONE));

   // R8: an errored non-queued completion keeps its issue bit
   p_err_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (nq_done && eng_err && (busy_slot != BUSY_NONE) && !(run_wr && run_q && !run_wdata))
      |=> issue_bits[$past(busy_slot[IDX_W-1:0])]);

   // R9: an errored completion halts dispatch
   p_err_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (nq_done && eng_err && !(run_wr && run_q && !run_wdata)) |=> (halt && !disp_valid));

endmodule

bind sata_slot_tracker sst_checker #(.N(NUM_SLOTS), .IDX_W(TAG_W)) u_sst_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run_wr      (run_wr),
   .run_wdata   (run_wdata),
   .run_q       (run_q),
   .halt        (halt),
   .eng_err     (eng_err),
   .eng_busy    (eng_busy),
   .eng_drq     (eng_drq),
   .nq_done     (nq_done),
   .disp_valid  (disp_valid),
   .disp_slot   (disp_slot),
   .busy_slot   (busy_slot),
   .issue_bits  (issue_bits),
   .active_bits (active_bits)
);

// File: tb/sata_slot_tracker_test.sv
module sata_slot_tracker_test;

   localparam int N = 32;
   localparam int TW = 5;
   localparam logic [TW:0] IDLE = 6'd32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic run_wr, run_wdata, issue_wr, active_wr;
   logic [N-1:0] issue_wdata, active_wdata;
   logic eng_err, eng_busy, eng_drq, disp_ready, nq_done, q_done, sdb_post;
   logic [TW-1:0] q_done_tag;
   logic disp_valid, disp_queued;
   logic [TW-1:0] disp_slot;
   logic [TW:0] busy_slot;
   logic [N-1:0] issue_bits, active_bits;

   sata_slot_tracker #(.NUM_SLOTS(N)) uut (.*);

   int checks = 0;
   int fails  = 0;

   // bench model state, built from the requirements
   logic [N-1:0] m_issue, m_active, m_fin;
   logic m_run, m_halt, m_bvld, m_qchk;
   logic [TW-1:0] m_bslot, m_qslot;

   function automatic logic [TW-1:0] lowest(logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return TW'(i);
      return '0;
   endfunction

   function automatic logic m_dv();
      return m_run && (m_issue != '0) && !eng_busy && !eng_drq && !m_halt && !m_bvld && !m_qchk;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle_inputs();
      run_wr = 0; run_wdata = 0; issue_wr = 0; issue_wdata = '0;
      active_wr = 0; active_wdata = '0; eng_err = 0; eng_busy = 0; eng_drq = 0;
      disp_ready = 0; nq_done = 0; q_done = 0; q_done_tag = '0; sdb_post = 0;
   endtask

   // compare all outputs against the model, then advance one clock
   task automatic cyc();
      logic fall, clean, hs, mq;
      logic [TW-1:0] ms;
      logic [N-1:0] clr;
      #1;
      ms = lowest(m_issue);
      mq = m_active[ms];
      chk("R2 issue bitmap", 64'(issue_bits), 64'(m_issue));
      chk("R10 active bitmap", 64'(active_bits), 64'(m_active));
      chk("R4 disp_valid", 64'(disp_valid), 64'(m_dv()));
      if (m_dv()) begin
         chk("R4 disp_slot", 64'(disp_slot), 64'(ms));
         chk("R6 disp_queued", 64'(disp_queued), 64'(mq));
      end
      chk("R7 busy_slot", 64'(busy_slot), 64'(m_bvld ? {1'b0, m_bslot} : IDLE));
      fall  = run_wr && m_run && !run_wdata;
      clean = !eng_err && !eng_busy && !eng_drq;
      hs    = m_dv() && disp_ready;
      clr   = '0;
      if (m_qchk && clean) clr[m_qslot] = 1'b1;
      if (nq_done && m_bvld && clean) clr[m_bslot] = 1'b1;
      @(posedge clk);
      m_issue  = (m_issue | (issue_wr ? issue_wdata : '0)) & ~clr;
      m_active = (m_active | (active_wr ? active_wdata : '0)) & ~(sdb_post ? m_fin : '0);
      m_fin    = (sdb_post ? '0 : m_fin) | ((q_done && !eng_err) ? (N'(1) << q_done_tag) : '0);
      m_halt   = m_halt || (eng_err && (nq_done || q_done || m_qchk));
      if (nq_done) m_bvld = 1'b0;
      else if (hs && !mq) begin m_bvld = 1'b1; m_bslot = ms; end
      m_qchk = hs && mq;
      if (hs) m_qslot = ms;
      if (run_wr) m_run = run_wdata;
      if (fall) begin
         m_issue = '0; m_active = '0; m_fin = '0;
         m_halt = 0; m_bvld = 0; m_qchk = 0;
      end
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin
      idle_inputs();
      m_issue = '0; m_active = '0; m_fin = '0; m_run = 0; m_halt = 0;
      m_bvld = 0; m_qchk = 0; m_bslot = '0; m_qslot = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 reset issue", 64'(issue_bits), 0);
      chk("R1 reset active", 64'(active_bits), 0);
      chk("R1 reset valid", 64'(disp_valid), 0);
      chk("R1 reset busy marker", 64'(busy_slot), 64'(IDLE));

      run_wr = 1; run_wdata = 1; cyc();
      issue_wr = 1; issue_wdata = 32'h14; active_wr = 1; active_wdata = 32'h10; cyc();
      #1;
      chk("R2 issue after set", 64'(issue_bits), 64'h14);
      chk("R4 lowest slot", 64'(disp_slot), 2);
      issue_wr = 1; issue_wdata = 32'h100; cyc();
      #1;
      chk("R2 OR-set keeps bits", 64'(issue_bits), 64'h114);
      eng_busy = 1; #1;
      chk("R5 busy blocks dispatch", 64'(disp_valid), 0);
      cyc();
      eng_drq = 1; disp_ready = 1; #1;
      chk("R5 drq blocks dispatch", 64'(disp_valid), 0);
      cyc();
      #1;
      chk("R5 slot kept pending", 64'(issue_bits), 64'h114);
      disp_ready = 1; cyc();
      #1;
      chk("R7 busy slot loaded", 64'(busy_slot), 2);
      chk("R7 busy blocks dispatch", 64'(disp_valid), 0);
      nq_done = 1; cyc();
      #1;
      chk("R7 clean completion clears", 64'(issue_bits), 64'h110);
      chk("R7 marker restored", 64'(busy_slot), 64'(IDLE));
      chk("R6 queued offered", 64'({disp_valid, disp_queued, disp_slot}), 64'({2'b11, 5'd4}));
      disp_ready = 1; cyc();
      #1;
      chk("R6 no dispatch in check cycle", 64'(disp_valid), 0);
      cyc();
      #1;
      chk("R6 queued issue cleared", 64'(issue_bits), 64'h100);
      q_done = 1; q_done_tag = 5'd4; cyc();
      #1;
      chk("R10 active kept until post", 64'(active_bits), 64'h10);
      sdb_post = 1; cyc();
      #1;
      chk("R10 finished tag removed", 64'(active_bits), 0);
      disp_ready = 1; cyc();
      nq_done = 1; eng_err = 1; cyc();
      #1;
      chk("R8 errored slot kept", 64'(issue_bits), 64'h100);
      chk("R9 halted after error", 64'(disp_valid), 0);
      issue_wr = 1; issue_wdata = 32'h1; active_wr = 1; active_wdata = 32'h80; cyc();
      #1;
      chk("R9 still halted", 64'(disp_valid), 0);
      run_wr = 1; run_wdata = 0; issue_wr = 1; issue_wdata = 32'h2; cyc();
      #1;
      chk("R3 issue wiped", 64'(issue_bits), 0);
      chk("R3 active wiped", 64'(active_bits), 0);
      run_wr = 1; run_wdata = 1; issue_wr = 1; issue_wdata = 32'h8; active_wr = 1; active_wdata = 32'h8; cyc();
      #1;
      chk("R9 halt cleared by fall", 64'({disp_valid, disp_slot}), 64'({1'b1, 5'd3}));
      disp_ready = 1; cyc();
      eng_err = 1; cyc();
      #1;
      chk("R6 errored check keeps bit", 64'(issue_bits), 64'h8);
      chk("R9 queued error halts", 64'(disp_valid), 0);
      q_done = 1; q_done_tag = 5'd3; eng_err = 1; cyc();
      sdb_post = 1; cyc();
      #1;
      chk("R10 errored tag stays active", 64'(active_bits), 64'h8);
      run_wr = 1; run_wdata = 0; cyc();
      run_wr = 1; run_wdata = 1; cyc();

      // constrained random phase with a fixed seed
      void'($urandom(32'd1234));
      for (int n = 0; n < 4000; n++) begin
         if (n % 97 == 96) begin run_wr = 1; run_wdata = 0; end
         else if (n % 97 == 0) begin run_wr = 1; run_wdata = 1; end
         else if ($urandom_range(0, 199) == 0) begin run_wr = 1; run_wdata = $urandom_range(0, 1); end
         if ($urandom_range(0, 5) == 0) begin
            issue_wr = 1; issue_wdata = $urandom() & $urandom() & $urandom();
         end
         if ($urandom_range(0, 7) == 0) begin
            active_wr = 1; active_wdata = $urandom() & $urandom() & $urandom();
         end
         eng_err    = ($urandom_range(0, 39) == 0);
         eng_busy   = ($urandom_range(0, 5) == 0);
         eng_drq    = ($urandom_range(0, 9) == 0);
         disp_ready = ($urandom_range(0, 2) != 0);
         nq_done    = m_bvld ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 49) == 0);
         q_done     = ($urandom_range(0, 4) == 0);
         q_done_tag = TW'($urandom_range(0, N - 1));
         sdb_post   = ($urandom_range(0, 6) == 0);
         cyc();
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule